// File: doc/BRIEF.md
# SDRAM Bank Command Sequencer

This block sits between a simple request port and the command pins of a four-bank SDRAM with a 32-bit data path. It accepts one request at a time and turns it into the shortest legal run of SDRAM commands. A request is a read or write with bank, row, column and an auto-precharge hint, a close-all request, or a mode-register load.

For each bank the block records whether a row is open and which row it is. A read or write then becomes a direct access, a precharge followed by an activation, or a plain activation. Cycle-count parameters set the row-precharge, activate-to-access and mode-load recovery times. Per-bank and global down-counters hold back any command until the relevant window has passed. NOP is driven on every cycle without a command.

Top module: `sdram_cmd_seq`

## Requirements
- R1: After reset, and on every cycle without a command, the pins {cs_n, ras_n, cas_n, we_n} read 0111 (NOP), and `req_ready_o` is high. The other command codes are: ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, mode load 0000. The request operation codes are: 0 read, 1 write, 2 close all banks, 3 mode load.
- R2: A read or write to a bank with no open row issues ACTIVE with the bank on `sd_ba_o` and the row on `sd_a_o`, then the access.
- R3: A read or write to the open row of its bank issues only READ or WRITE. The column is on `sd_a_o[7:0]` and the auto-precharge hint is on `sd_a_o[10]`.
- R4: A read or write to a different row of an open bank issues PRECHARGE for that bank only (`sd_a_o[10]`=0), then ACTIVE, then the access.
- R5: ACTIVE to a bank comes no sooner than T_RP cycles after a PRECHARGE that closed it.
- R6: READ or WRITE comes no sooner than T_RCD cycles after the ACTIVE of its bank.
- R7: An access with the hint set closes the row. The next request to that bank starts with ACTIVE, with no PRECHARGE before it. That ACTIVE comes no sooner than BURST_LEN+T_RP cycles after the access.
- R8: A close-all request issues one PRECHARGE with `sd_a_o[10]`=1. After it, every bank needs ACTIVE before an access.
- R9: A mode load is issued only when no bank is open and every bank's recovery time has elapsed, with the mode value on `sd_a_o[11:0]`. If any bank is open, a PRECHARGE with `sd_a_o[10]`=1 is issued first.
- R10: No command follows a mode load sooner than T_MRD cycles.
- R11: `req_ready_o` is low from the cycle after a request is accepted until its last command has been issued. At most one command is issued per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Ready to accept a request |
| req_op_i | input | 2 | Operation: 0 read, 1 write, 2 close all, 3 mode load |
| req_bank_i | input | 2 | Target bank |
| req_row_i | input | 12 | Row address, or the mode value for a mode load |
| req_col_i | input | 8 | Starting column |
| req_ap_i | input | 1 | Auto-precharge hint for read and write |
| sd_cs_n_o | output | 1 | Chip select, active low |
| sd_ras_n_o | output | 1 | Row strobe, active low |
| sd_cas_n_o | output | 1 | Column strobe, active low |
| sd_we_n_o | output | 1 | Write enable, active low |
| sd_ba_o | output | 2 | Bank address |
| sd_a_o | output | 12 | Address bus |

## Verification
Two functions can meet in one cycle: a bank's recovery counter reaching zero, and the evaluation of a pending request that needs that bank. The same holds for the global counters that gate a mode load. The bench provokes this by sending the next request straight after an auto-precharge access, a close-all, or a mode load, so the request is already waiting when the counter expires. It then judges the cycle gap between the two commands on the pins against the exact value derived from the timing parameters. An early command shows a counter released too soon, and a late one shows an extra stall.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } cmd_e;

  typedef enum logic [1:0] {
    OP_RD    = 2'd0,
    OP_WR    = 2'd1,
    OP_CLOSE = 2'd2,
    OP_MODE  = 2'd3
  } op_e;

  typedef enum logic {S_IDLE, S_BUSY} state_e;
endpackage

// File: rtl/sdram_wait_cnt.sv
module sdram_wait_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  p_cnt_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/sdram_bank_state.sv
module sdram_bank_state #(
  parameter int ROW_W   = 12,
  parameter int CNT_W   = 8,
  parameter int TRP_LD  = 2,
  parameter int APRE_LD = 6,
  parameter int TRCD_LD = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic             rw_i,
  input  logic             ap_i,
  input  logic             pre_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             act_ok_o,
  output logic             rw_ok_o
);
  logic             open_q;
  logic [ROW_W-1:0] row_q;
  logic             close_ap;
  logic [CNT_W-1:0] rec_val;

  assign close_ap = rw_i && ap_i;
  assign rec_val  = pre_i ? CNT_W'(TRP_LD) : CNT_W'(APRE_LD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      row_q  <= '0;
    end else if (act_i) begin
      open_q <= 1'b1;
      row_q  <= row_i;
    end else if (pre_i || close_ap) begin
      open_q <= 1'b0;
    end
  end

  // recovery window before the next activation
  sdram_wait_cnt #(.CNT_W(CNT_W)) i_rec_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(pre_i || close_ap),
    .val_i (rec_val),
    .zero_o(act_ok_o)
  );

  // activate-to-access window
  sdram_wait_cnt #(.CNT_W(CNT_W)) i_rcd_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(act_i),
    .val_i (CNT_W'(TRCD_LD)),
    .zero_o(rw_ok_o)
  );

  assign open_o = open_q;
  assign row_o  = row_q;

  p_act_closed_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |-> (!open_q && act_ok_o));
  p_rw_open_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rw_i |-> (open_q && rw_ok_o));
  p_one_cmd_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({act_i, rw_i, pre_i}) <= 1);
  p_open_after_act_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |=> open_q);
endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdram_seq_pkg::*;
#(
  parameter int BANKS     = 4,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 8,
  parameter int T_RP      = 3,
  parameter int T_RCD     = 2,
  parameter int T_MRD     = 2,
  parameter int BURST_LEN = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_valid_i,
  output logic                     req_ready_o,
  input  logic [1:0]               req_op_i,
  input  logic [$clog2(BANKS)-1:0] req_bank_i,
  input  logic [ROW_W-1:0]         req_row_i,
  input  logic [COL_W-1:0]         req_col_i,
  input  logic                     req_ap_i,
  output logic                     sd_cs_n_o,
  output logic                     sd_ras_n_o,
  output logic                     sd_cas_n_o,
  output logic                     sd_we_n_o,
  output logic [$clog2(BANKS)-1:0] sd_ba_o,
  output logic [ROW_W-1:0]         sd_a_o
);
  localparam int BA_W    = $clog2(BANKS);
  localparam int AP_BIT  = 10;
  localparam int CNT_W   = $clog2(BURST_LEN + T_RP + T_RCD + T_MRD + 1) + 1;
  localparam int TRP_LD  = T_RP - 1;
  localparam int TRCD_LD = T_RCD - 1;
  localparam int MRD_LD  = T_MRD - 1;
  localparam int APRE_LD = BURST_LEN + T_RP - 1;

  state_e           state_q;
  op_e              op_q;
  logic [BA_W-1:0]  bank_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             ap_q;

  logic [BANKS-1:0]            open_v, act_ok_v, rw_ok_v, act_v, rw_v, pre_v;
  logic [BANKS-1:0][ROW_W-1:0] row_v;

  logic             mrd_ok, done;
  logic             do_act, do_rw, do_pre_one, do_pre_all, do_lmr;
  cmd_e             cmd_n, cmd_q;
  logic [BA_W-1:0]  ba_n, ba_q;
  logic [ROW_W-1:0] a_n, a_q;

  assign req_ready_o = (state_q == S_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      op_q    <= OP_RD;
      bank_q  <= '0;
      row_q   <= '0;
      col_q   <= '0;
      ap_q    <= 1'b0;
    end else if (state_q == S_IDLE) begin
      if (req_valid_i) begin
        state_q <= S_BUSY;
        op_q    <= op_e'(req_op_i);
        bank_q  <= req_bank_i;
        row_q   <= req_row_i;
        col_q   <= req_col_i;
        ap_q    <= req_ap_i;
      end
    end else if (done) begin
      state_q <= S_IDLE;
    end
  end

  // command selection for the held request
  always_comb begin
    cmd_n      = CMD_NOP;
    ba_n       = '0;
    a_n        = '0;
    done       = 1'b0;
    do_act     = 1'b0;
    do_rw      = 1'b0;
    do_pre_one = 1'b0;
    do_pre_all = 1'b0;
    do_lmr     = 1'b0;
    if (state_q == S_BUSY && mrd_ok) begin
      unique case (op_q)
        OP_CLOSE: begin
          do_pre_all  = 1'b1;
          done        = 1'b1;
        end
        OP_MODE: begin
          if (|open_v) begin
            do_pre_all = 1'b1;
          end else if (&act_ok_v) begin
            do_lmr = 1'b1;
            done   = 1'b1;
          end
        end
        default: begin
          if (open_v[bank_q]) begin
            if (row_v[bank_q] == row_q) begin
              if (rw_ok_v[bank_q]) begin
                do_rw = 1'b1;
                done  = 1'b1;
              end
            end else begin
              do_pre_one = 1'b1;
            end
          end else if (act_ok_v[bank_q]) begin
            do_act = 1'b1;
          end
        end
      endcase
    end
    if (do_pre_all) begin
      cmd_n          = CMD_PRE;
      a_n[AP_BIT]    = 1'b1;
    end else if (do_pre_one) begin
      cmd_n = CMD_PRE;
      ba_n  = bank_q;
    end else if (do_act) begin
      cmd_n = CMD_ACT;
      ba_n  = bank_q;
      a_n   = row_q;
    end else if (do_rw) begin
      cmd_n              = (op_q == OP_WR) ? CMD_WR : CMD_RD;
      ba_n               = bank_q;
      a_n[COL_W-1:0]     = col_q;
      a_n[AP_BIT]        = ap_q;
    end else if (do_lmr) begin
      cmd_n = CMD_LMR;
      a_n   = row_q;
    end
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign act_v[b] = do_act && (bank_q == BA_W'(b));
    assign rw_v[b]  = do_rw && (bank_q == BA_W'(b));
    assign pre_v[b] = do_pre_all || (do_pre_one && (bank_q == BA_W'(b)));

    sdram_bank_state #(
      .ROW_W  (ROW_W),
      .CNT_W  (CNT_W),
      .TRP_LD (TRP_LD),
      .APRE_LD(APRE_LD),
      .TRCD_LD(TRCD_LD)
    ) i_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .act_i   (act_v[b]),
      .rw_i    (rw_v[b]),
      .ap_i    (ap_q),
      .pre_i   (pre_v[b]),
      .row_i   (row_q),
      .open_o  (open_v[b]),
      .row_o   (row_v[b]),
      .act_ok_o(act_ok_v[b]),
      .rw_ok_o (rw_ok_v[b])
    );
  end

  sdram_wait_cnt #(.CNT_W(CNT_W)) i_mrd_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(do_lmr),
    .val_i (CNT_W'(MRD_LD)),
    .zero_o(mrd_ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= CMD_NOP;
      ba_q  <= '0;
      a_q   <= '0;
    end else begin
      cmd_q <= cmd_n;
      ba_q  <= ba_n;
      a_q   <= a_n;
    end
  end

  assign {sd_cs_n_o, sd_ras_n_o, sd_cas_n_o, sd_we_n_o} = cmd_q;
  assign sd_ba_o = ba_q;
  assign sd_a_o  = a_q;

  p_lmr_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_lmr |-> (open_v == '0 && (&act_ok_v)));
  p_mrd_gap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (T_MRD > 1 && cmd_q == CMD_LMR) |=> (cmd_q == CMD_NOP));
  p_all_closed_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_pre_all |=> (open_v == '0));
  p_busy_ready_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o && req_valid_i) |=> !req_ready_o);
endmodule

// File: tb/test_sdram_cmd_seq.sv
module test_sdram_cmd_seq;
  localparam int CLK_P = 10;
  localparam int T_RP  = 3;
  localparam int T_RCD = 2;
  localparam int T_MRD = 2;
  localparam int BL    = 4;
  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                         C_WR = 4'b0100, C_PRE = 4'b0010, C_LMR = 4'b0000;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        req_valid = 1'b0, req_ready, req_ap = 1'b0;
  logic [1:0]  req_op = '0, req_bank = '0, sd_ba;
  logic [11:0] req_row = '0, sd_a;
  logic [7:0]  req_col = '0;
  logic        cs_n, ras_n, cas_n, we_n;

  int n_chk = 0, n_fail = 0, cyc = 0, n_log = 0;
  logic [3:0]  log_cmd[64];
  logic [1:0]  log_ba[64];
  logic [11:0] log_a[64];
  int          log_cyc[64];

  always #(CLK_P/2) clk = ~clk;

  sdram_cmd_seq #(.T_RP(T_RP), .T_RCD(T_RCD), .T_MRD(T_MRD), .BURST_LEN(BL)) i_sdram_cmd_seq (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_op_i(req_op), .req_bank_i(req_bank), .req_row_i(req_row), .req_col_i(req_col),
    .req_ap_i(req_ap), .sd_cs_n_o(cs_n), .sd_ras_n_o(ras_n), .sd_cas_n_o(cas_n),
    .sd_we_n_o(we_n), .sd_ba_o(sd_ba), .sd_a_o(sd_a));

  always @(negedge clk) begin
    cyc++;
    if (rst_ni && {cs_n, ras_n, cas_n, we_n} != C_NOP && n_log < 64) begin
      log_cmd[n_log] = {cs_n, ras_n, cas_n, we_n};
      log_ba[n_log]  = sd_ba;
      log_a[n_log]   = sd_a;
      log_cyc[n_log] = cyc;
      n_log++;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(int op, int bank, int row, int col, bit ap);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_op = 2'(op); req_bank = 2'(bank); req_row = 12'(row);
    req_col = 8'(col); req_ap = ap; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic settle();
    while (!req_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 reset cmd", {cs_n, ras_n, cas_n, we_n}, C_NOP);
    chk("R1 reset ready", req_ready, 1);
  endtask

  task automatic t_idle_activate();
    int b = n_log;
    send(0, 1, 'h123, 'h45, 0);
    settle();
    chk("R2 count", n_log - b, 2);
    chk("R2 act cmd", log_cmd[b], C_ACT);
    chk("R2 act ba", log_ba[b], 1);
    chk("R2 act row", log_a[b], 'h123);
    chk("R3 rd cmd", log_cmd[b+1], C_RD);
    chk("R3 rd col", log_a[b+1][7:0], 'h45);
    chk("R6 trcd gap", log_cyc[b+1] - log_cyc[b], T_RCD);
  endtask

  task automatic t_hit();
    int b = n_log;
    send(1, 1, 'h123, 'h10, 0);
    settle();
    chk("R3 hit count", n_log - b, 1);
    chk("R3 wr cmd", log_cmd[b], C_WR);
    chk("R3 wr col", log_a[b][7:0], 'h10);
    chk("R3 wr a10", log_a[b][10], 0);
  endtask

  task automatic t_miss();
    int b = n_log;
    send(0, 1, 'h200, 'h03, 0);
    chk("R11 busy ready", req_ready, 0);
    settle();
    chk("R4 count", n_log - b, 3);
    chk("R4 pre cmd", log_cmd[b], C_PRE);
    chk("R4 pre a10", log_a[b][10], 0);
    chk("R4 pre ba", log_ba[b], 1);
    chk("R4 act cmd", log_cmd[b+1], C_ACT);
    chk("R4 act row", log_a[b+1], 'h200);
    chk("R5 trp gap", log_cyc[b+1] - log_cyc[b], T_RP);
    chk("R4 rd cmd", log_cmd[b+2], C_RD);
    chk("R6 trcd gap", log_cyc[b+2] - log_cyc[b+1], T_RCD);
  endtask

  task automatic t_auto_pre();
    int b = n_log;
    send(1, 1, 'h200, 'h07, 1);
    send(0, 1, 'h200, 'h08, 0);
    settle();
    chk("R7 count", n_log - b, 3);
    chk("R7 wr cmd", log_cmd[b], C_WR);
    chk("R7 wr a10", log_a[b][10], 1);
    chk("R7 act no pre", log_cmd[b+1], C_ACT);
    chk("R7 recovery gap", log_cyc[b+1] - log_cyc[b], BL + T_RP);
  endtask

  task automatic t_close_all();
    int b;
    send(0, 2, 'h005, 'h01, 0);
    send(0, 3, 'h006, 'h02, 0);
    settle();
    b = n_log;
    send(2, 0, 0, 0, 0);
    send(0, 1, 'h200, 'h09, 0);
    settle();
    chk("R8 pre cmd", log_cmd[b], C_PRE);
    chk("R8 pre a10", log_a[b][10], 1);
    chk("R8 act after close", log_cmd[b+1], C_ACT);
    chk("R8 gap", log_cyc[b+1] - log_cyc[b], T_RP);
  endtask

  task automatic t_lmr_open();
    int b = n_log;
    send(3, 0, 'h032, 0, 0);
    send(0, 0, 'h001, 'h02, 1);
    settle();
    chk("R9 count", n_log - b, 4);
    chk("R9 pre first", log_cmd[b], C_PRE);
    chk("R9 pre a10", log_a[b][10], 1);
    chk("R9 lmr cmd", log_cmd[b+1], C_LMR);
    chk("R9 lmr value", log_a[b+1], 'h032);
    chk("R9 lmr after trp", log_cyc[b+1] - log_cyc[b], T_RP);
    chk("R10 act after lmr", log_cmd[b+2], C_ACT);
    chk("R10 tmrd gap", log_cyc[b+2] - log_cyc[b+1], T_MRD);
    chk("R7 rd a10", log_a[b+3][10], 1);
  endtask

  task automatic t_lmr_idle();
    int b = n_log;
    send(3, 0, 'h021, 0, 0);
    settle();
    chk("R9 direct count", n_log - b, 1);
    chk("R9 direct lmr", log_cmd[b], C_LMR);
    chk("R9 direct value", log_a[b], 'h021);
    chk("R9 waits recovery", log_cyc[b] - log_cyc[b-1], BL + T_RP);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_activate();
    t_hit();
    t_miss();
    t_auto_pre();
    t_close_all();
    t_lmr_open();
    t_lmr_idle();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule